// File: doc/BRIEF.md
# PTP System Time Counter

The block keeps a running precision-time value made of a 32-bit seconds count and a 31-bit sub-second count. On each reference clock the sub-second count can gain a programmable 8-bit step. In coarse mode the step is applied on every cycle. In fine mode it is applied only on cycles where a 32-bit rate accumulator carries out. That accumulator gains a 32-bit addend on every enabled cycle, so software trims the effective frequency by changing the addend.

The sub-second count rolls over in one of two encodings, chosen at run time. In decimal mode one LSB is 1 ns, and the count wraps when it reaches 1,000,000,000. In binary mode one LSB is 2^-31 s (about 0.466 ns), and the count wraps when it reaches 2^31. Each wrap adds one to the seconds count, and the seconds count itself wraps from 0xFFFFFFFF to 0.

Software starts the time with a one-cycle initialize strobe that carries preload values. The `init_busy` output shows that a load is in progress.

A three-state controller sequences the block:
- ST_HOLD is the suspended state.
- ST_RUN is the counting state.
- ST_LOAD is the one-cycle preload state.

Its transitions are:
- hold_to_run: enable is high and there is no strobe.
- run_to_hold: enable is low.
- any_to_load: enable and strobe are both high outside ST_LOAD.
- load_exit: leads to ST_RUN if enable is high, otherwise to ST_HOLD.

Top module: `ptp_time_core`

## Requirements
- R1: After reset, `sec_out` and `subsec_out` are 0, `init_busy` is 0, and the rate accumulator is 0.
- R2: In coarse mode (`fine_mode`=0), every clock edge that finds the controller in ST_RUN with `ts_enable`=1 adds `incr` to the sub-second count.
- R3: In fine mode (`fine_mode`=1), every edge with `ts_enable`=1 adds `addend` to the 32-bit accumulator, modulo 2^32. The sub-second count gains `incr` only on a ST_RUN edge where that addition carries out of bit 31.
- R4: While `ts_enable`=0 and no load is in progress, the seconds count, the sub-second count and the accumulator all hold.
- R5: An `init_start` strobe seen at an edge with `ts_enable`=1, outside ST_LOAD, captures `init_sec` and `init_subsec` at that edge. It raises `init_busy` for exactly one cycle. At the following edge the outputs take the captured values.
- R6: `init_start` is ignored in two cases: while `init_busy` is 1, and while `ts_enable` is 0. In both cases `init_busy` stays as it was and the time is not changed.
- R7: The edge that applies the preload adds no increment, because the preload takes priority over a same-cycle step.
- R8: With `dec_rollover`=1, a step that brings the sub-second sum to 1,000,000,000 or above stores the sum minus 1,000,000,000 and adds one to the seconds count.
- R9: With `dec_rollover`=0, a step that brings the sub-second sum to 2^31 or above stores the sum minus 2^31 and adds one to the seconds count.
- R10: The seconds count wraps from 0xFFFFFFFF to 0.
- R11: Leaving ST_HOLD costs one edge. The edge that first sees `ts_enable`=1 moves the controller to ST_RUN without a step, and counting starts at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ts_enable | input | 1 | Time generator enable; low suspends the generator |
| init_start | input | 1 | Initialize strobe |
| init_sec | input | 32 | Seconds preload value |
| init_subsec | input | 31 | Sub-second preload value |
| fine_mode | input | 1 | 1 selects stepping on accumulator carry, 0 selects stepping every cycle |
| incr | input | 8 | Sub-second step value |
| addend | input | 32 | Rate accumulator addend |
| dec_rollover | input | 1 | 1 selects decimal-nanosecond rollover, 0 selects binary rollover |
| sec_out | output | 32 | Current seconds |
| subsec_out | output | 31 | Current sub-seconds |
| init_busy | output | 1 | High while a preload is pending |

## Verification
The bench places the sub-second count a few steps below both rollover limits. A design that compared against the wrong limit, or cleared the count instead of subtracting, would store a value that disagrees with the expected remainder. It also preloads 0xFFFFFFFF seconds with a pending rollover, so a seconds counter that saturates or loses its carry is exposed. In fine mode the bench uses addends of one half, one quarter, all-ones and zero. A step taken on the wrong cycle would shift the whole timeline, and so would a dropped accumulator carry. The bench also holds the strobe for two cycles and strobes while the generator is disabled. A design that reloaded, stretched `init_busy`, or stepped during the load cycle would diverge from the scoreboard.

// File: rtl/ptp_time_pkg.sv
package ptp_time_pkg;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_RUN  = 2'd1,
        ST_LOAD = 2'd2
    } tc_state_e;

endpackage

// File: rtl/ptp_rate_acc.sv
module ptp_rate_acc #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [ACC_W-1:0] addend,
    output logic             carry
);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   sum;

    assign sum   = {1'b0, acc_q} + {1'b0, addend};
    assign carry = en & sum[ACC_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (en) begin
            acc_q <= sum[ACC_W-1:0];
        end
    end

    // R4: a disabled accumulator keeps its phase
    p_acc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(acc_q));

    // R3: a carry means the stored phase wrapped below its old value plus addend
    p_acc_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        carry |=> (acc_q < $past(addend) || $past(addend) == '0));

endmodule

// File: rtl/ptp_subsec_adv.sv
module ptp_subsec_adv #(
    parameter int SUB_W      = 31,
    parameter int INC_W      = 8,
    parameter int NS_PER_SEC = 1_000_000_000
) (
    input  logic [SUB_W-1:0] subsec_in,
    input  logic [INC_W-1:0] incr,
    input  logic             dec_mode,
    output logic [SUB_W-1:0] subsec_nxt,
    output logic             wrap
);

    localparam logic [SUB_W:0] LIM_DEC = (SUB_W+1)'(NS_PER_SEC);
    localparam logic [SUB_W:0] LIM_BIN = {1'b1, {SUB_W{1'b0}}};

    logic [SUB_W:0] sum;
    logic [SUB_W:0] lim;
    logic [SUB_W:0] red;

    always_comb begin
        sum        = {1'b0, subsec_in} + {{(SUB_W+1-INC_W){1'b0}}, incr};
        lim        = dec_mode ? LIM_DEC : LIM_BIN;
        wrap       = (sum >= lim);
        red        = wrap ? (sum - lim) : sum;
        subsec_nxt = red[SUB_W-1:0];
    end

endmodule

// File: rtl/ptp_time_core.sv
module ptp_time_core
    import ptp_time_pkg::*;
#(
    parameter int SEC_W      = 32,
    parameter int SUB_W      = 31,
    parameter int INC_W      = 8,
    parameter int ACC_W      = 32,
    parameter int NS_PER_SEC = 1_000_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ts_enable,
    input  logic             init_start,
    input  logic [SEC_W-1:0] init_sec,
    input  logic [SUB_W-1:0] init_subsec,
    input  logic             fine_mode,
    input  logic [INC_W-1:0] incr,
    input  logic [ACC_W-1:0] addend,
    input  logic             dec_rollover,
    output logic [SEC_W-1:0] sec_out,
    output logic [SUB_W-1:0] subsec_out,
    output logic             init_busy
);

    tc_state_e        state_q, state_d;
    logic [SEC_W-1:0] sec_q, sh_sec_q;
    logic [SUB_W-1:0] sub_q, sh_sub_q;
    logic             busy_q;
    logic             acc_carry;
    logic [SUB_W-1:0] sub_nxt;
    logic             sub_wrap;
    logic             cnt_en;
    logic             adv;
    logic             init_take;

    ptp_rate_acc #(.ACC_W(ACC_W)) u_rate (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (ts_enable),
        .addend (addend),
        .carry  (acc_carry)
    );

    ptp_subsec_adv #(
        .SUB_W      (SUB_W),
        .INC_W      (INC_W),
        .NS_PER_SEC (NS_PER_SEC)
    ) u_adv (
        .subsec_in  (sub_q),
        .incr       (incr),
        .dec_mode   (dec_rollover),
        .subsec_nxt (sub_nxt),
        .wrap       (sub_wrap)
    );

    assign cnt_en    = (state_q == ST_RUN) && ts_enable;
    assign adv       = cnt_en && (fine_mode ? acc_carry : 1'b1);
    assign init_take = ts_enable && init_start && (state_q != ST_LOAD);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: begin
                if (init_take)      state_d = ST_LOAD;
                else if (ts_enable) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (init_take)       state_d = ST_LOAD;
                else if (!ts_enable) state_d = ST_HOLD;
            end
            ST_LOAD: begin
                state_d = ts_enable ? ST_RUN : ST_HOLD;
            end
            default: state_d = ST_HOLD;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    // time and busy outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_q    <= '0;
            sub_q    <= '0;
            sh_sec_q <= '0;
            sh_sub_q <= '0;
            busy_q   <= 1'b0;
        end else begin
            if (state_q == ST_LOAD) begin
                sec_q <= sh_sec_q;
                sub_q <= sh_sub_q;
            end else if (adv) begin
                sub_q <= sub_nxt;
                if (sub_wrap) sec_q <= sec_q + 1'b1;
            end
            if (init_take) begin
                sh_sec_q <= init_sec;
                sh_sub_q <= init_subsec;
            end
            busy_q <= (state_d == ST_LOAD);
        end
    end

    assign sec_out    = sec_q;
    assign subsec_out = sub_q;
    assign init_busy  = busy_q;

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ts_enable && state_q != ST_LOAD) |=> ($stable(sec_q) && $stable(sub_q)));

    p_busy_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        init_busy |=> !init_busy);

    p_load_val_r5: assert property (@(posedge clk) disable iff (!rst_n)
        init_busy |=> (sec_out == $past(sh_sec_q) && subsec_out == $past(sh_sub_q)));

    p_ignore_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (init_start && !ts_enable && !init_busy) |=> !init_busy);

    p_coarse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !fine_mode && !sub_wrap) |=> (sub_q == $past(sub_q) + SUB_W'($past(incr))));

    p_fine_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && fine_mode && !acc_carry) |=> $stable(sub_q));

    p_sec_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_LOAD) |=> (sec_q == $past(sec_q) || sec_q == $past(sec_q) + 1'b1));

endmodule

// File: tb/ptp_time_core_bench.sv
module ptp_time_core_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ts_enable = 1'b0;
    logic        init_start = 1'b0;
    logic [31:0] init_sec = '0;
    logic [30:0] init_subsec = '0;
    logic        fine_mode = 1'b0;
    logic [7:0]  incr = '0;
    logic [31:0] addend = '0;
    logic        dec_rollover = 1'b1;
    logic [31:0] sec_out;
    logic [30:0] subsec_out;
    logic        init_busy;

    always #5 clk = ~clk;

    ptp_time_core u_ptp_time_core (
        .clk(clk), .rst_n(rst_n), .ts_enable(ts_enable), .init_start(init_start),
        .init_sec(init_sec), .init_subsec(init_subsec), .fine_mode(fine_mode),
        .incr(incr), .addend(addend), .dec_rollover(dec_rollover),
        .sec_out(sec_out), .subsec_out(subsec_out), .init_busy(init_busy)
    );

    typedef struct {
        logic [31:0] s;
        logic [30:0] ss;
        logic        b;
        string       tag;
    } exp_t;

    exp_t  sb_q[$];
    int    errors = 0;
    int    checks = 0;
    string phase = "R1";

    // reference model: 0 hold, 1 run, 2 load
    int          m_st = 0;
    logic [31:0] m_sec = '0, m_shs = '0, m_acc = '0;
    logic [30:0] m_sub = '0, m_shss = '0;
    logic        m_busy = 1'b0;

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            longint unsigned asum, lim, ssum;
            logic carry, take;
            int   nst;
            @(posedge clk);
            asum  = longint'(m_acc) + longint'(addend);
            carry = ts_enable && (asum >= 64'h1_0000_0000);
            take  = ts_enable && init_start && (m_st != 2);
            if (m_st == 2) begin
                m_sec = m_shs;
                m_sub = m_shss;
            end else if (m_st == 1 && ts_enable && (!fine_mode || carry)) begin
                lim  = dec_rollover ? 64'd1_000_000_000 : 64'h8000_0000;
                ssum = longint'(m_sub) + longint'(incr);
                if (ssum >= lim) begin
                    ssum  = ssum - lim;
                    m_sec = m_sec + 32'd1;
                end
                m_sub = ssum[30:0];
            end
            if (ts_enable) m_acc = asum[31:0];
            if (take) begin
                m_shs  = init_sec;
                m_shss = init_subsec;
                nst    = 2;
            end else begin
                nst = ts_enable ? 1 : 0;
            end
            m_st   = nst;
            m_busy = (nst == 2);
            sb_q.push_back('{m_sec, m_sub, m_busy, phase});
            @(negedge clk);
        end
    endtask

    task automatic do_init(input logic [31:0] s, input logic [30:0] ss);
        init_sec    = s;
        init_subsec = ss;
        init_start  = 1'b1;
        cyc(1);
        init_start  = 1'b0;
        cyc(1);
    endtask

    // monitor: compare each produced result against the scoreboard
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (sec_out !== e.s || subsec_out !== e.ss || init_busy !== e.b) begin
                errors++;
                $display("FAIL %s: got sec=%h sub=%0d busy=%b, expected sec=%h sub=%0d busy=%b",
                         e.tag, sec_out, subsec_out, init_busy, e.s, e.ss, e.b);
            end
        end
    end

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        checks++;
        if (sec_out !== 32'd0 || subsec_out !== 31'd0 || init_busy !== 1'b0) begin
            errors++;
            $display("FAIL R1: got sec=%h sub=%0d busy=%b, expected 0 0 0",
                     sec_out, subsec_out, init_busy);
        end
        @(negedge clk);
        phase = "R1"; cyc(2);
        // R11: first edge of enable only moves to run
        phase = "R11"; ts_enable = 1'b1; incr = 8'd20; dec_rollover = 1'b1; cyc(4);
        // R5 / R7: preload, then no step on the load edge
        phase = "R5"; do_init(32'd5, 31'd999_999_900);
        phase = "R7"; cyc(1);
        // R8: decimal rollover
        phase = "R8"; cyc(8);
        // R6: strobe held across the busy cycle
        phase = "R6"; init_sec = 32'd77; init_subsec = 31'd1234; init_start = 1'b1; cyc(2);
        init_start = 1'b0; init_sec = 32'd99; cyc(3);
        // R9: binary rollover
        phase = "R9"; dec_rollover = 1'b0; incr = 8'd43;
        do_init(32'd10, 31'h7FFF_FF9C); cyc(6);
        // R10: seconds wrap
        phase = "R10"; dec_rollover = 1'b1; incr = 8'd20;
        do_init(32'hFFFF_FFFF, 31'd999_999_970); cyc(4);
        // R3: fine mode with several addends
        phase = "R3"; fine_mode = 1'b1; addend = 32'h8000_0000;
        do_init(32'd100, 31'd0); cyc(8);
        addend = 32'h4000_0000; cyc(12);
        addend = 32'hFFFF_FFFF; cyc(4);
        addend = 32'h0; cyc(4);
        addend = 32'h5555_5555; cyc(9);
        // R4: suspend holds time and accumulator phase
        phase = "R4"; ts_enable = 1'b0; cyc(5);
        phase = "R6"; init_sec = 32'd1; init_start = 1'b1; cyc(2);
        init_start = 1'b0;
        phase = "R4"; ts_enable = 1'b1; cyc(8);
        // R2: coarse stepping with extreme increments
        phase = "R2"; fine_mode = 1'b0; incr = 8'd255; cyc(6);
        incr = 8'd0; cyc(3);
        incr = 8'd1; cyc(3);
        #2;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule